// File: doc/BRIEF.md
# Downstream Superframe Decoder with Token-Granted Upstream Burst

This block sits in every optical network unit of a point-to-multipoint timing network. It takes the recovered downstream stream, one decoded byte per clock with a flag that marks control characters. It locks to the superframe on the comma and then walks through the fixed layout that follows. Every subframe carries a trigger byte, which the block presents on each subframe. Each command pair is delivered when it is meant for every unit, or when the subframe number equals this unit's own address.

The superframe ends with a token byte. When the token carries this unit's address, the block owns the shared upstream fibre for one window. That window begins at the next comma. For the whole window the laser enable is high. The serial output first sends an alternating training pattern, then the status word sampled at the start of the window, then zeros. When the window ends the laser turns off. All other units keep their lasers dark.

Top module: `onu_sf_decoder`

## Requirements
- R1: After reset, trig_valid, cmd_valid, frame_err, laser_en and tx_bit are all 0, and the decoder waits for a comma.
- R2: Any byte with rx_k = 1 is a comma. After a comma the bytes form subframes numbered from 1. Subframes 1 to 64 are four bytes each: trigger, spare, command byte A, command byte B. Subframe 65 is three bytes: trigger, spare, token. After the token the decoder waits for a comma, and bytes without rx_k are ignored while it waits.
- R3: trig_valid pulses for one cycle with trig_byte equal to the trigger byte, in the cycle after that byte is taken. This happens in all 65 subframes.
- R4: In the cycle after command byte B is taken, the command is delivered as follows. If bit 0 of command byte A is 0, cmd_valid pulses with cmd_bcast = 1 and cmd_data = {A, B}. If bit 0 is 1, cmd_valid pulses with cmd_bcast = 0 only when the subframe number equals my_addr. Otherwise nothing is delivered.
- R5: A comma that arrives before the token of subframe 65 raises frame_err for one cycle, and the byte after it is the trigger byte of subframe 1.
- R6: A token equal to my_addr arms a burst. The burst starts on the next comma. laser_en is high from the cycle after that comma for exactly BURST_LEN cycles (default 260).
- R7: The first TRAIN_LEN bits of a burst (default 128) alternate, starting with 1.
- R8: After the training, status_word as sampled at the burst-starting comma is sent MSB first over 32 cycles, followed by 0 until the window ends.
- R9: Without a matching token, laser_en stays 0. Whenever laser_en is 0, tx_bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Decoded downstream byte |
| rx_k | input | 1 | Byte is a comma control character |
| my_addr | input | 8 | This unit's address |
| status_word | input | 32 | Upstream payload |
| trig_valid | output | 1 | Trigger byte strobe |
| trig_byte | output | 8 | Trigger type byte |
| cmd_valid | output | 1 | Command strobe |
| cmd_bcast | output | 1 | Delivered command is for all units |
| cmd_data | output | 16 | Command bytes A and B |
| frame_err | output | 1 | Early comma pulse |
| laser_en | output | 1 | Upstream laser enable |
| tx_bit | output | 1 | Upstream serial bit |

## Verification
Each byte passes through one register level, so a trigger, command or framing error is due in the cycle right after the byte that causes it. The bench applies one byte per clock just after a rising edge and reads the outputs one edge later. It therefore compares each strobe against the byte it has just sent. For bursts, the bench logs laser_en and tx_bit after every byte of the superframe that follows the matching token. Entry k of that log is compared with burst bit k, and the first byte after the window is checked for a dark laser.

// File: rtl/onu_sf_decoder.sv
module onu_sf_decoder #(
  parameter int SUBFRAMES = 65,
  parameter int TRAIN_LEN = 128,
  parameter int BURST_LEN = 260,
  parameter int STATUS_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          rx_byte,
  input  logic                rx_k,
  input  logic [7:0]          my_addr,
  input  logic [STATUS_W-1:0] status_word,
  output logic                trig_valid,
  output logic [7:0]          trig_byte,
  output logic                cmd_valid,
  output logic                cmd_bcast,
  output logic [15:0]         cmd_data,
  output logic                frame_err,
  output logic                laser_en,
  output logic                tx_bit
);
  localparam int SUB_W   = $clog2(SUBFRAMES + 1);
  localparam int BC_W    = $clog2(BURST_LEN);
  localparam int PAY_END = TRAIN_LEN + STATUS_W;

  logic                locked, pend, active;
  logic [1:0]          pos;
  logic [SUB_W-1:0]    sub;
  logic [7:0]          cmd_a;
  logic [BC_W-1:0]     bcnt;
  logic [STATUS_W-1:0] shreg;

  wire last_sub = (sub == SUB_W'(SUBFRAMES));
  wire in_train = int'(bcnt) < TRAIN_LEN;
  wire in_pay   = !in_train && int'(bcnt) < PAY_END;

  assign laser_en = active;
  assign tx_bit   = active && (in_train ? ~bcnt[0] : (in_pay && shreg[STATUS_W-1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0; pend <= 1'b0; active <= 1'b0;
      pos <= '0; sub <= '0; cmd_a <= '0; bcnt <= '0; shreg <= '0;
      trig_valid <= 1'b0; trig_byte <= '0;
      cmd_valid <= 1'b0; cmd_bcast <= 1'b0; cmd_data <= '0;
      frame_err <= 1'b0;
    end else begin
      trig_valid <= 1'b0;
      cmd_valid  <= 1'b0;
      frame_err  <= 1'b0;
      if (active) begin
        if (bcnt == BC_W'(BURST_LEN - 1)) active <= 1'b0;
        else bcnt <= bcnt + BC_W'(1);
        if (in_pay) shreg <= {shreg[STATUS_W-2:0], 1'b0};
      end
      if (rx_k) begin
        frame_err <= locked;
        locked    <= 1'b1;
        sub       <= SUB_W'(1);
        pos       <= '0;
        if (pend) begin
          pend   <= 1'b0;
          active <= 1'b1;
          bcnt   <= '0;
          shreg  <= status_word;
        end
      end else if (locked) begin
        pos <= pos + 2'd1;
        case (pos)
          2'd0: begin
            trig_valid <= 1'b1;
            trig_byte  <= rx_byte;
          end
          2'd2: begin
            if (last_sub) begin
              locked <= 1'b0;
              if (rx_byte == my_addr) pend <= 1'b1;
            end else cmd_a <= rx_byte;
          end
          2'd3: begin
            cmd_valid <= !cmd_a[0] || (8'(sub) == my_addr);
            cmd_bcast <= !cmd_a[0];
            cmd_data  <= {cmd_a, rx_byte};
            sub       <= sub + SUB_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_cmd_apart: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !trig_valid);
  a_r5_err_from_comma: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(rx_k));
  a_r6_burst_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(laser_en) |-> $past(rx_k));
  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    laser_en |-> int'(bcnt) < BURST_LEN);
  a_r7_train_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bcnt != '0 && in_train) |-> (tx_bit != $past(tx_bit)));
  a_r9_dark_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !laser_en |-> !tx_bit);
endmodule

// File: tb/sim_onu_sf_decoder.sv
module sim_onu_sf_decoder;
  logic clk = 0, rst_n = 0, rx_k = 0;
  logic [7:0] rx_byte = 0, my_addr = 0;
  logic [31:0] status_word = 0;
  logic trig_valid, cmd_valid, cmd_bcast, frame_err, laser_en, tx_bit;
  logic [7:0] trig_byte;
  logic [15:0] cmd_data;
  int n_chk = 0, n_fail = 0;
  logic las_log [260];
  logic tx_log [260];
  int idx = -1;

  always #10 clk = ~clk;

  onu_sf_decoder u0 (.clk, .rst_n, .rx_byte, .rx_k, .my_addr, .status_word,
    .trig_valid, .trig_byte, .cmd_valid, .cmd_bcast, .cmd_data,
    .frame_err, .laser_en, .tx_bit);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic k);
    rx_byte = b; rx_k = k;
    @(posedge clk); #1;
    if (idx >= 0 && idx < 260) begin las_log[idx] = laser_en; tx_log[idx] = tx_bit; idx++; end
  endtask

  task automatic send_sf(input logic [7:0] tok, input logic odd);
    send(8'hBC, 1);
    for (int s = 1; s <= 65; s++) begin
      send(8'(s), 0);
      chk(trig_valid && trig_byte == 8'(s), "R3 trigger", trig_byte, s);
      send(8'h00, 0);
      if (s < 65) begin
        send({s[6:0], odd}, 0);
        send(~8'(s), 0);
        if (!odd || 8'(s) == my_addr)
          chk(cmd_valid && cmd_bcast == !odd && cmd_data == {s[6:0], odd, ~8'(s)},
              "R4 command", cmd_data, {s[6:0], odd, ~8'(s)});
        else chk(!cmd_valid, "R4 not addressed", cmd_valid, 0);
      end else begin
        send(tok, 0);
        chk(!cmd_valid && !trig_valid, "R2 token byte", cmd_valid, 0);
      end
    end
  endtask

  task automatic t_reset;
    chk(!trig_valid && !cmd_valid && !frame_err && !laser_en && !tx_bit, "R1 reset", laser_en, 0);
    send(8'h11, 0);
    send(8'h22, 0);
    chk(!trig_valid && !cmd_valid, "R2 ignored while hunting", trig_valid, 0);
  endtask

  task automatic t_broadcast;
    my_addr = 8'd200;
    send_sf(8'd7, 0);
    send(8'h33, 0);
    chk(!trig_valid && !laser_en, "R2 waits after token", trig_valid, 0);
  endtask

  task automatic t_addressed;
    my_addr = 8'd5;
    send_sf(8'd9, 1);
  endtask

  task automatic t_early_comma;
    my_addr = 8'd1;
    send(8'hBC, 1);
    chk(!frame_err, "R5 first comma clean", frame_err, 0);
    send(8'h40, 0); send(8'h00, 0); send(8'h03, 0); send(8'h44, 0);
    send(8'h41, 0);
    send(8'hBC, 1);
    chk(frame_err, "R5 early comma flagged", frame_err, 1);
    send(8'h77, 0);
    chk(!frame_err && trig_valid && trig_byte == 8'h77, "R5 resync trigger", trig_byte, 8'h77);
    send(8'h00, 0); send(8'h03, 0); send(8'h5A, 0);
    chk(cmd_valid && !cmd_bcast && cmd_data == 16'h035A, "R5 restarts at subframe 1", cmd_data, 16'h035A);
    for (int s = 2; s <= 64; s++) begin send(8'h0, 0); send(8'h0, 0); send(8'h0, 0); send(8'h0, 0); end
    send(8'h0, 0); send(8'h0, 0); send(8'h0, 0);
  endtask

  task automatic t_burst;
    my_addr = 8'd42;
    status_word = 32'hA5C3_0F96;
    send_sf(8'd42, 0);
    chk(!laser_en, "R6 laser waits for comma", laser_en, 0);
    idx = 0;
    send_sf(8'd3, 0);
    idx = -1;
    for (int i = 0; i < 260; i++) begin
      logic e;
      e = (i < 128) ? ~i[0] : (i < 160) ? status_word[31 - (i - 128)] : 1'b0;
      chk(las_log[i], "R6 laser window", las_log[i], 1);
      chk(tx_log[i] == e, (i < 128) ? "R7 training" : "R8 payload", tx_log[i], e);
    end
    send(8'h00, 0);
    chk(!laser_en && !tx_bit, "R6 laser off after window", laser_en, 0);
  endtask

  task automatic t_no_token;
    my_addr = 8'd42;
    idx = 0;
    send_sf(8'd43, 1);
    idx = -1;
    for (int i = 0; i < 260; i++)
      chk(!las_log[i] && !tx_log[i], "R9 dark without token", las_log[i], 0);
    send(8'hBC, 1);
    chk(!laser_en, "R9 no burst after mismatch", laser_en, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_broadcast;
    t_addressed;
    t_early_comma;
    t_burst;
    t_no_token;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule